// File: doc/BRIEF.md
# Convolutional Encoder with Rate-3/4 Puncturing

This block takes a serial stream of data bits and turns it into a serial stream of coded bits. Either of two rate-1/2 feed-forward codes can be used: a constraint-length-6 code or a constraint-length-4 code. It can send both coded bits of every input bit, which gives rate 1/2. It can also steal bits over groups of three input bits, which gives rate 3/4. Input bits arrive over a valid/ready handshake. Coded bits leave over a second valid/ready handshake, and the consumer can hold that handshake off for as long as it likes.

Between frames, a one-cycle start pulse clears the code memory, the puncturing phase and any coded bits still waiting to leave. At the end of a frame, a one-cycle flush pulse makes the block feed K-1 zero tail bits through the same encoder and puncturing path, so the code memory ends at zero. The rate and code selects are expected to stay constant during a frame.

Top module: `conv_punct_enc`

## Requirements
- R1: With `code_k4`=0 and `rate34`=0, every accepted bit produces two coded bits, A first and then B. A is the XOR over the generator 65 octal and B is the XOR over 57 octal. Generator bit 5 taps the new bit and bit 0 taps the bit from five inputs earlier. A single 1 into a cleared encoder, followed by a flush, produces 1,1,1,0,0,1,1,1,0,1,1,1.
- R2: With `code_k4`=1, the generators are 15 octal (A) and 17 octal (B). Generator bit 3 taps the new bit and bit 0 taps the bit from three inputs earlier.
- R3: With `rate34`=1, a phase counter cycles 0,1,2 and advances once for every bit entering the encoder, whether a data bit or a tail bit. Phase 0 emits A then B, phase 1 emits only A, and phase 2 emits only B.
- R4: A `flush` pulse, accepted when no tail is in progress, injects K-1 zero bits: 5 for the K=6 code and 3 for the K=4 code. The code memory is zero afterwards. A later frame that has no start pulse therefore encodes as if from a cleared state, and its puncturing phase carries on from where it stood.
- R5: A `frame_start` pulse clears the code memory, the puncturing phase and any pending coded bits, whatever state the block is in.
- R6: `in_ready` is low while coded bits are waiting to be emitted or tail bits remain to be injected. It is high otherwise.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_bit` holds its value.
- R8: After reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse that clears memory, phase and pending bits |
| code_k4 | input | 1 | 0: K=6 code (65/57 octal), 1: K=4 code (15/17 octal) |
| rate34 | input | 1 | 0: rate 1/2, 1: rate 3/4 punctured |
| flush | input | 1 | One-cycle pulse requesting K-1 zero tail bits |
| in_valid | input | 1 | Input bit valid |
| in_bit | input | 1 | Data bit |
| in_ready | output | 1 | Encoder can take a data bit |
| out_valid | output | 1 | Coded bit valid |
| out_bit | output | 1 | Coded bit |
| out_ready | input | 1 | Consumer takes the coded bit |

## Verification
The hardest case to reach is a frame that starts with no start pulse right after a flush. Only then do the zeroed memory and the carried-over puncturing phase both show at the ports. The stimulus table therefore places a rate-3/4 frame without a start pulse after a flushed frame whose accept count leaves the phase at 1. A second hard case is a start pulse that lands on a block holding an unflushed frame. A frame without a flush is followed by a start pulse and an impulse, and the result must match the hand-derived impulse response. Backpressure is applied at irregular spacing so that stalls fall on every puncturing phase.

// File: rtl/cpe_pkg.sv
package cpe_pkg;

  // Parity of the taps selected by a generator over a window (MSB = newest bit)
  function automatic logic tap_parity(input logic [5:0] win, input logic [5:0] gen);
    return ^(win & gen);
  endfunction

  // Which coded bits survive: bit0 keeps A, bit1 keeps B
  function automatic logic [1:0] keep_mask(input logic r34, input logic [1:0] phase);
    if (!r34)            return 2'b11;
    else if (phase == 0) return 2'b11;
    else if (phase == 1) return 2'b01;
    else                 return 2'b10;
  endfunction

  // Next puncturing phase in a cycle of three
  function automatic logic [1:0] next_phase(input logic [1:0] phase);
    return (phase == 2'd2) ? 2'd0 : phase + 2'd1;
  endfunction

endpackage

// File: rtl/cpe_shift.sv
module cpe_shift #(
  parameter int K_LONG  = 6,
  parameter int K_SHORT = 4,
  parameter logic [K_LONG-1:0]  GL_A = 6'o65,
  parameter logic [K_LONG-1:0]  GL_B = 6'o57,
  parameter logic [K_SHORT-1:0] GS_A = 4'o15,
  parameter logic [K_SHORT-1:0] GS_B = 4'o17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       shift_en,
  input  logic       din,
  input  logic       k4,
  output logic [1:0] pair,
  output logic       state_clear
);
  import cpe_pkg::*;
  localparam int MEM  = K_LONG - 1;
  localparam int SMEM = K_SHORT - 1;
  localparam int PADW = K_LONG - K_SHORT;

  logic [MEM-1:0] sr;   // sr[MEM-1] is the most recent bit
  logic [K_LONG-1:0] win_long, win_short, ga, gb, wsel;

  assign win_long  = {din, sr};
  assign win_short = {{PADW{1'b0}}, din, sr[MEM-1 -: SMEM]};
  assign wsel = k4 ? win_short : win_long;
  assign ga   = k4 ? {{PADW{1'b0}}, GS_A} : GL_A;
  assign gb   = k4 ? {{PADW{1'b0}}, GS_B} : GL_B;

  assign pair[0] = tap_parity(wsel, ga);
  assign pair[1] = tap_parity(wsel, gb);

  assign state_clear = k4 ? (sr[MEM-1 -: SMEM] == '0) : (sr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr <= '0;
    else if (clear)    sr <= '0;
    else if (shift_en) sr <= {din, sr[MEM-1:1]};
  end
endmodule

// File: rtl/cpe_phase.sv
module cpe_phase (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       step,
  input  logic       r34,
  output logic [1:0] phase,
  output logic [1:0] keep
);
  import cpe_pkg::*;

  assign keep = keep_mask(r34, phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           phase <= 2'd0;
    else if (clear)       phase <= 2'd0;
    else if (step && r34) phase <= next_phase(phase);
  end
endmodule

// File: rtl/cpe_serial.sv
module cpe_serial (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       load,
  input  logic [1:0] keep,
  input  logic [1:0] pair,
  input  logic       out_ready,
  output logic       out_valid,
  output logic       out_bit,
  output logic       empty,
  output logic [1:0] cnt
);
  logic [1:0] hold;

  assign out_valid = (cnt != 2'd0);
  assign out_bit   = hold[0];
  assign empty     = (cnt == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= 2'b00;
      cnt  <= 2'd0;
    end else if (clear) begin
      hold <= 2'b00;
      cnt  <= 2'd0;
    end else if (load) begin
      case (keep)
        2'b11:   begin hold <= {pair[1], pair[0]}; cnt <= 2'd2; end
        2'b01:   begin hold <= {1'b0, pair[0]};    cnt <= 2'd1; end
        2'b10:   begin hold <= {1'b0, pair[1]};    cnt <= 2'd1; end
        default: begin hold <= 2'b00;              cnt <= 2'd0; end
      endcase
    end else if (out_valid && out_ready) begin
      hold <= {1'b0, hold[1]};
      cnt  <= cnt - 2'd1;
    end
  end
endmodule

// File: rtl/conv_punct_enc.sv
module conv_punct_enc #(
  parameter int K_LONG  = 6,
  parameter int K_SHORT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic code_k4,
  input  logic rate34,
  input  logic flush,
  input  logic in_valid,
  input  logic in_bit,
  output logic in_ready,
  output logic out_valid,
  output logic out_bit,
  input  logic out_ready
);
  localparam int TW = $clog2(K_LONG);
  localparam logic [TW-1:0] TAIL_LONG  = TW'(K_LONG - 1);
  localparam logic [TW-1:0] TAIL_SHORT = TW'(K_SHORT - 1);

  logic [TW-1:0] tail_left;
  logic       empty, data_go, tail_go, step, din, tail_last, state_clear;
  logic [1:0] pair, keep, phase, cnt;

  assign in_ready  = empty && (tail_left == '0);
  assign data_go   = in_valid && in_ready && !frame_start;
  assign tail_go   = (tail_left != '0) && empty && !frame_start;
  assign step      = data_go || tail_go;
  assign din       = tail_go ? 1'b0 : in_bit;
  assign tail_last = tail_go && (tail_left == TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         tail_left <= '0;
    else if (frame_start)               tail_left <= '0;
    else if (flush && tail_left == '0)  tail_left <= code_k4 ? TAIL_SHORT : TAIL_LONG;
    else if (tail_go)                   tail_left <= tail_left - TW'(1);
  end

  cpe_shift #(.K_LONG(K_LONG), .K_SHORT(K_SHORT)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(frame_start), .shift_en(step),
    .din(din), .k4(code_k4), .pair(pair), .state_clear(state_clear)
  );

  cpe_phase u_phase (
    .clk(clk), .rst_n(rst_n), .clear(frame_start), .step(step),
    .r34(rate34), .phase(phase), .keep(keep)
  );

  cpe_serial u_serial (
    .clk(clk), .rst_n(rst_n), .clear(frame_start), .load(step),
    .keep(keep), .pair(pair), .out_ready(out_ready),
    .out_valid(out_valid), .out_bit(out_bit), .empty(empty), .cnt(cnt)
  );
endmodule

// File: rtl/cpe_checker.sv
module cpe_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_start,
  input logic       rate34,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_bit,
  input logic       step,
  input logic       tail_last,
  input logic       state_clear,
  input logic [1:0] phase,
  input logic [1:0] cnt
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (in_ready && !out_valid)); // R8

  AST_HALF_TWO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !rate34 && !frame_start) |=> (cnt == 2'd2)); // R1

  AST_PUNCT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && rate34 && phase != 2'd0 && !frame_start) |=> (cnt == 2'd1)); // R3

  AST_TAIL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_last && !frame_start) |=> state_clear); // R4

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (state_clear && phase == 2'd0 && !out_valid)); // R5

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !frame_start) |=> (out_valid && $stable(out_bit))); // R7
endmodule

bind conv_punct_enc cpe_checker u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rate34(rate34),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_bit(out_bit), .step(step), .tail_last(tail_last),
  .state_clear(state_clear), .phase(phase), .cnt(cnt)
);

// File: tb/conv_punct_enc_bench.sv
module conv_punct_enc_bench;
  logic clk = 0, rst_n = 0;
  logic frame_start = 0, code_k4 = 0, rate34 = 0, flush = 0;
  logic in_valid = 0, in_bit = 0, out_ready = 1;
  logic in_ready, out_valid, out_bit;

  int tests = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  conv_punct_enc u_conv_punct_enc (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .code_k4(code_k4),
    .rate34(rate34), .flush(flush), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .out_valid(out_valid), .out_bit(out_bit),
    .out_ready(out_ready)
  );

  // Vector: [31] start pulse, [30] K=4 code, [29] rate 3/4, [28] flush,
  //         [27:23] data length, [22] backpressure, [15:0] data (bit 0 first)
  localparam int NV = 8;
  localparam logic [31:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 1'b1, 5'd1,  1'b0, 6'd0, 16'h0001},
    {1'b1, 1'b1, 1'b0, 1'b1, 5'd8,  1'b1, 6'd0, 16'h00B5},
    {1'b1, 1'b0, 1'b1, 1'b1, 5'd10, 1'b0, 6'd0, 16'h02CF},
    {1'b1, 1'b1, 1'b1, 1'b1, 5'd7,  1'b1, 6'd0, 16'h004D},
    {1'b0, 1'b1, 1'b1, 1'b1, 5'd5,  1'b0, 6'd0, 16'h0013},
    {1'b1, 1'b0, 1'b1, 1'b0, 5'd4,  1'b1, 6'd0, 16'h000F},
    {1'b1, 1'b0, 1'b0, 1'b1, 5'd1,  1'b1, 6'd0, 16'h0001},
    {1'b1, 1'b0, 1'b1, 1'b1, 5'd0,  1'b0, 6'd0, 16'h0000}
  };
  // Hand-derived impulse response of the K=6 code at rate 1/2 (bit 0 first)
  localparam logic [11:0] IMP6 = 12'b111011100111;

  localparam logic [5:0] GA6 = 6'b110101, GB6 = 6'b101111;
  localparam logic [3:0] GA4 = 4'b1101,   GB4 = 4'b1111;

  logic [5:0] m_hist;   // m_hist[d-1] = input from d steps back
  int m_phase;
  logic exp_bits [64];
  logic cap_bits [64];
  int exp_n, cap_n;
  int busy_viol, hold_viol;

  function automatic string tag_of(input int i);
    case (i)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R3";
      4: return "R4";
      5: return "R3";
      6: return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic model_push(input logic u, input logic k4, input logic r34);
    logic a, b;
    int kk;
    kk = k4 ? 4 : 6;
    a = u & (k4 ? GA4[3] : GA6[5]);
    b = u & (k4 ? GB4[3] : GB6[5]);
    for (int d = 1; d < kk; d++) begin
      a ^= m_hist[d-1] & (k4 ? GA4[3-d] : GA6[5-d]);
      b ^= m_hist[d-1] & (k4 ? GB4[3-d] : GB6[5-d]);
    end
    m_hist = {m_hist[4:0], u};
    if (!r34 || m_phase == 0) begin
      exp_bits[exp_n] = a; exp_bits[exp_n+1] = b; exp_n += 2;
    end else if (m_phase == 1) begin
      exp_bits[exp_n] = a; exp_n += 1;
    end else begin
      exp_bits[exp_n] = b; exp_n += 1;
    end
    if (r34) m_phase = (m_phase + 1) % 3;
  endtask

  task automatic run_vec(input int vi);
    logic [31:0] v;
    int n, idx, quiet, guard;
    bit flushed, done, prev_stall, prev_bit, mism;
    v = VEC[vi];
    n = int'(v[27:23]);
    exp_n = 0; cap_n = 0;
    code_k4 = v[30]; rate34 = v[29];
    if (v[31]) begin
      m_hist = '0; m_phase = 0;
      @(negedge clk) frame_start = 1;
      @(negedge clk) frame_start = 0;
    end
    for (int i = 0; i < n; i++) model_push(v[i], v[30], v[29]);
    if (v[28]) for (int i = 0; i < (v[30] ? 3 : 5); i++) model_push(1'b0, v[30], v[29]);
    idx = 0; quiet = 0; guard = 0; flushed = !v[28]; prev_stall = 0; prev_bit = 0;
    done = 0;
    while (!done) begin
      @(negedge clk);
      out_ready = v[22] ? ((cyc % 3) != 1 && (cyc % 7) != 3) : 1'b1;
      in_valid  = (idx < n);
      in_bit    = (idx < n) ? v[idx] : 1'b0;
      flush     = (!flushed && idx == n);
      if (flush) flushed = 1;
      #1;
      if (out_valid && in_ready) busy_viol++;
      if (prev_stall && (!out_valid || out_bit != prev_bit)) hold_viol++;
      prev_stall = out_valid && !out_ready;
      prev_bit   = out_bit;
      if (out_valid && out_ready) begin
        if (cap_n < 64) cap_bits[cap_n] = out_bit;
        cap_n++;
      end
      if (in_valid && in_ready) idx++;
      if (idx == n && flushed && cap_n >= exp_n) quiet++;
      done = (quiet >= 10);
      guard++;
      if (guard > 3000) begin
        check(0, tag_of(vi), "frame timeout", cap_n, exp_n);
        done = 1;
      end
    end
    @(negedge clk);
    in_valid = 0; flush = 0; out_ready = 1;
    check(cap_n == exp_n, tag_of(vi), $sformatf("vector %0d coded bit count", vi), cap_n, exp_n);
    mism = 0;
    for (int i = 0; i < exp_n && i < 64; i++)
      if (cap_bits[i] !== exp_bits[i]) begin
        if (!mism)
          check(0, tag_of(vi), $sformatf("vector %0d bit %0d", vi, i), int'(cap_bits[i]), int'(exp_bits[i]));
        mism = 1;
      end
    if (!mism) check(1, tag_of(vi), "bits", 0, 0);
    if (vi == 0 || vi == 6) begin
      mism = 0;
      for (int i = 0; i < 12; i++) if (cap_bits[i] !== IMP6[i]) mism = 1;
      check(!mism && cap_n == 12, (vi == 0) ? "R1" : "R5", "impulse response vs hand value", cap_n, 12);
    end
  endtask

  initial begin
    int tmo;
    tmo = 150000;
    fork
      begin
        busy_viol = 0; hold_viol = 0;
        m_hist = '0; m_phase = 0;
        repeat (3) @(negedge clk);
        #1;
        check(in_ready === 1'b1, "R8", "in_ready during reset", int'(in_ready), 1);
        check(out_valid === 1'b0, "R8", "out_valid during reset", int'(out_valid), 0);
        @(negedge clk) rst_n = 1;
        @(negedge clk); #1;
        check(in_ready === 1'b1 && out_valid === 1'b0, "R8", "idle after reset",
              int'({in_ready, out_valid}), 2);
        for (int vi = 0; vi < NV; vi++) run_vec(vi);
        check(busy_viol == 0, "R6", "in_ready high while bits pending", busy_viol, 0);
        check(hold_viol == 0, "R7", "output changed under backpressure", hold_viol, 0);
        // R6: a single accept closes the input until both coded bits leave
        code_k4 = 0; rate34 = 0;
        @(negedge clk) frame_start = 1;
        @(negedge clk) begin frame_start = 0; out_ready = 0; in_valid = 1; in_bit = 1; end
        @(negedge clk) in_valid = 0;
        #1;
        check(in_ready === 1'b0 && out_valid === 1'b1, "R6", "ready low after accept",
              int'({in_ready, out_valid}), 1);
        repeat (4) @(negedge clk);
        #1;
        check(out_valid === 1'b1 && out_bit === 1'b1, "R7", "held first bit under stall",
              int'({out_valid, out_bit}), 3);
        out_ready = 1;
        repeat (2) @(negedge clk);
        #1;
        check(in_ready === 1'b1 && out_valid === 1'b0, "R6", "ready back after drain",
              int'({in_ready, out_valid}), 2);
      end
      begin
        while (cyc < tmo) @(posedge clk);
        check(0, "ALL", "watchdog expired", cyc, tmo);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule